// File: doc/BRIEF.md
# SRAM Boundary-Scan Test Access Port

This block is the test access port of a synchronous SRAM. It follows the IEEE 1149.1 model. A sixteen-state controller is stepped by TMS on the rising edge of TCK. A 3-bit instruction selects one of three data paths between TDI and TDO:

- a one-stage bypass path;
- a 32-bit identification register, whose device code depends on whether the memory is built 36 or 18 bits wide;
- a 71-bit boundary chain. The chain captures the parallel pin values and presents them again on parallel update outputs.

Two instructions capture the pins and also raise a request that the surrounding memory core uses to float its output drivers. A third instruction captures and preloads the chain without raising that request. The identification and bypass instructions leave the memory core untouched. TDO is retimed to the falling edge of TCK. It is driven only while an instruction or a data register is being shifted.

Reset is a synchronous, active-high input sampled on the TCK rising edge. Holding TMS high also reaches the reset state, and in the same edge it restores the identification instruction.

Top module: `sram_tap`

## Requirements
- R1: While `tap_reset` is high at a TCK rising edge, the controller enters Test-Logic-Reset, the active instruction becomes identification (001), `hiz_req` and all bits of `bsr_update` go to 0, and from the next falling edge `tdo_en` and `tdo` are 0.
- R2: From any controller state, five consecutive TCK rising edges with TMS high reach Test-Logic-Reset. On the edge that enters that state, the active instruction becomes identification (001) and `hiz_req` drops. Four such edges starting from Shift-DR do not change the active instruction.
- R3: The instruction is shifted in LSB first from TDI and becomes active at Update-IR. The opcodes are: 000 external test, 001 identification, 010 sample-with-float, 100 sample/preload, 111 bypass. The reserved codes 011, 101 and 110 act as bypass.
- R4: Capture-IR loads 001 into the instruction shifter, so the first three bits shifted out on TDO are 1, 0, 0.
- R5: Under the identification instruction, Capture-DR loads a 32-bit word, which is shifted out LSB first. Its fields are: bits 31:29 = 000, bits 28:24 = 01011, bits 23:18 = 000000, bits 17:12 = 100110 when `WIDE_CFG` = 1 (x36) or 010110 when it is 0 (x18), bits 11:1 = 00000110100, bit 0 = 1.
- R6: Under bypass (and the reserved codes), Capture-DR loads 0 into a single stage, and TDO repeats TDI one TCK later.
- R7: Under external test, sample-with-float and sample/preload, Capture-DR loads `bsr_capture` into a 71-bit chain, shifted out bit 0 first. A bit shifted in from TDI reaches TDO after 71 shifts.
- R8: `bsr_update` changes only on the rising edge that leaves Update-DR while a boundary-chain instruction is active. It then takes the chain contents. Identification or bypass scans leave it unchanged.
- R9: `hiz_req` is 1 exactly while the active instruction is external test or sample-with-float. It changes only on leaving Update-IR or by reset.
- R10: TDO and `tdo_en` change on the TCK falling edge. `tdo_en` is 1 only when the controller is in Shift-IR or Shift-DR, and `tdo` is 0 whenever `tdo_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tap_reset | input | 1 | Synchronous active-high reset, sampled on TCK rise |
| tms | input | 1 | Mode select steering the controller |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, falling-edge timed |
| tdo_en | output | 1 | High while TDO carries shifted data |
| hiz_req | output | 1 | Request to float the memory output drivers |
| bsr_capture | input | 71 | Parallel pin values captured into the chain |
| bsr_update | output | 71 | Parallel values latched from the chain at Update-DR |

## Verification
The checker watches four properties on every cycle:
- `tdo_en` tracks the Shift states across the falling-edge retiming;
- `hiz_req` moves only at Update-IR or on entry to Test-Logic-Reset;
- `bsr_update` holds outside Update-DR;
- the reset values hold on the first cycle after reset.

The serial contents are shown only by the bench's directed scans. These are the captured instruction pattern, the bit-exact identification word, the one-cycle bypass delay, the 71-stage chain length shown with a 72-bit scan, and the full opcode decode including the reserved codes. The bench scans also show that an identification scan leaves the update outputs alone and that exactly five TMS-high edges are needed.

// File: rtl/sram_tap_pkg.sv
package sram_tap_pkg;

    localparam int IR_W  = 3;
    localparam int ID_W  = 32;
    localparam int BSR_W = 71;

    typedef enum logic [3:0] {
        S_TLR, S_RTI,
        S_SEL_DR, S_CAP_DR, S_SHF_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR, S_UPD_DR,
        S_SEL_IR, S_CAP_IR, S_SHF_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
    } tap_state_e;

    typedef enum logic [IR_W-1:0] {
        OP_EXTEST = 3'b000,
        OP_IDCODE = 3'b001,
        OP_SAMPZ  = 3'b010,
        OP_RSV3   = 3'b011,
        OP_SAMPLE = 3'b100,
        OP_RSV5   = 3'b101,
        OP_RSV6   = 3'b110,
        OP_BYPASS = 3'b111
    } opcode_e;

    typedef enum logic [1:0] {PATH_BYP, PATH_ID, PATH_BSR} dr_path_e;

    typedef struct packed {
        dr_path_e path;
        logic     hiz;
    } decode_t;

    localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

    function automatic tap_state_e tap_next(tap_state_e s, logic m);
        case (s)
            S_TLR:    return m ? S_TLR    : S_RTI;
            S_RTI:    return m ? S_SEL_DR : S_RTI;
            S_SEL_DR: return m ? S_SEL_IR : S_CAP_DR;
            S_CAP_DR: return m ? S_EX1_DR : S_SHF_DR;
            S_SHF_DR: return m ? S_EX1_DR : S_SHF_DR;
            S_EX1_DR: return m ? S_UPD_DR : S_PAU_DR;
            S_PAU_DR: return m ? S_EX2_DR : S_PAU_DR;
            S_EX2_DR: return m ? S_UPD_DR : S_SHF_DR;
            S_UPD_DR: return m ? S_SEL_DR : S_RTI;
            S_SEL_IR: return m ? S_TLR    : S_CAP_IR;
            S_CAP_IR: return m ? S_EX1_IR : S_SHF_IR;
            S_SHF_IR: return m ? S_EX1_IR : S_SHF_IR;
            S_EX1_IR: return m ? S_UPD_IR : S_PAU_IR;
            S_PAU_IR: return m ? S_EX2_IR : S_PAU_IR;
            S_EX2_IR: return m ? S_UPD_IR : S_SHF_IR;
            default:  return m ? S_SEL_DR : S_RTI;
        endcase
    endfunction

    function automatic decode_t op_decode(opcode_e op);
        decode_t d;
        case (op)
            OP_EXTEST, OP_SAMPZ: begin d.path = PATH_BSR; d.hiz = 1'b1; end
            OP_SAMPLE:           begin d.path = PATH_BSR; d.hiz = 1'b0; end
            OP_IDCODE:           begin d.path = PATH_ID;  d.hiz = 1'b0; end
            default:             begin d.path = PATH_BYP; d.hiz = 1'b0; end
        endcase
        return d;
    endfunction

    function automatic logic [ID_W-1:0] id_value(logic [5:0] dev_code);
        return {3'b000, 5'b01011, 6'b000000, dev_code, 11'b00000110100, 1'b1};
    endfunction

endpackage

// File: rtl/sram_tap_fsm.sv
module sram_tap_fsm
    import sram_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    output tap_state_e st,
    output tap_state_e nxt
);
    assign nxt = tap_next(st, tms);

    always_ff @(posedge tck) begin
        if (rst) st <= S_TLR;
        else     st <= nxt;
    end
endmodule

// File: rtl/sram_tap_ir.sv
module sram_tap_ir
    import sram_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tdi,
    input  tap_state_e st,
    input  tap_state_e nxt,
    output opcode_e    ir,
    output logic       ir_so
);
    logic [IR_W-1:0] ir_sr;

    assign ir_so = ir_sr[0];

    always_ff @(posedge tck) begin
        if (rst || nxt == S_TLR) begin
            ir    <= OP_IDCODE;
            ir_sr <= IR_CAPTURE;
        end else begin
            case (st)
                S_CAP_IR: ir_sr <= IR_CAPTURE;
                S_SHF_IR: ir_sr <= {tdi, ir_sr[IR_W-1:1]};
                S_UPD_IR: ir    <= opcode_e'(ir_sr);
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sram_tap_dr.sv
module sram_tap_dr
    import sram_tap_pkg::*;
#(
    parameter bit WIDE_CFG = 1'b1
) (
    input  logic             tck,
    input  logic             rst,
    input  logic             tdi,
    input  tap_state_e       st,
    input  dr_path_e         path,
    input  logic [BSR_W-1:0] bsr_capture,
    output logic [BSR_W-1:0] bsr_update,
    output logic             dr_so
);
    logic [ID_W-1:0]  id_word;
    logic             byp;
    logic [ID_W-1:0]  id_sr;
    logic [BSR_W-1:0] bsr_sr;

    if (WIDE_CFG) begin : g_x36
        assign id_word = id_value(6'b100110);
    end else begin : g_x18
        assign id_word = id_value(6'b010110);
    end

    always_comb begin
        case (path)
            PATH_ID:  dr_so = id_sr[0];
            PATH_BSR: dr_so = bsr_sr[0];
            default:  dr_so = byp;
        endcase
    end

    always_ff @(posedge tck) begin
        if (rst) begin
            byp        <= 1'b0;
            id_sr      <= '0;
            bsr_sr     <= '0;
            bsr_update <= '0;
        end else begin
            case (st)
                S_CAP_DR: begin
                    case (path)
                        PATH_ID:  id_sr  <= id_word;
                        PATH_BSR: bsr_sr <= bsr_capture;
                        default:  byp    <= 1'b0;
                    endcase
                end
                S_SHF_DR: begin
                    case (path)
                        PATH_ID:  id_sr  <= {tdi, id_sr[ID_W-1:1]};
                        PATH_BSR: bsr_sr <= {tdi, bsr_sr[BSR_W-1:1]};
                        default:  byp    <= tdi;
                    endcase
                end
                S_UPD_DR: begin
                    if (path == PATH_BSR) bsr_update <= bsr_sr;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sram_tap.sv
module sram_tap
    import sram_tap_pkg::*;
#(
    parameter bit WIDE_CFG = 1'b1
) (
    input  logic             tck,
    input  logic             tap_reset,
    input  logic             tms,
    input  logic             tdi,
    output logic             tdo,
    output logic             tdo_en,
    output logic             hiz_req,
    input  logic [BSR_W-1:0] bsr_capture,
    output logic [BSR_W-1:0] bsr_update
);
    tap_state_e st;
    tap_state_e nxt;
    opcode_e    ir;
    decode_t    dec;
    logic       ir_so;
    logic       dr_so;

    sram_tap_fsm u_fsm (
        .tck (tck),
        .rst (tap_reset),
        .tms (tms),
        .st  (st),
        .nxt (nxt)
    );

    sram_tap_ir u_ir (
        .tck   (tck),
        .rst   (tap_reset),
        .tdi   (tdi),
        .st    (st),
        .nxt   (nxt),
        .ir    (ir),
        .ir_so (ir_so)
    );

    assign dec     = op_decode(ir);
    assign hiz_req = dec.hiz;

    sram_tap_dr #(.WIDE_CFG(WIDE_CFG)) u_dr (
        .tck         (tck),
        .rst         (tap_reset),
        .tdi         (tdi),
        .st          (st),
        .path        (dec.path),
        .bsr_capture (bsr_capture),
        .bsr_update  (bsr_update),
        .dr_so       (dr_so)
    );

    always_ff @(negedge tck) begin
        if (tap_reset) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo_en <= (st == S_SHF_IR) || (st == S_SHF_DR);
            case (st)
                S_SHF_IR: tdo <= ir_so;
                S_SHF_DR: tdo <= dr_so;
                default:  tdo <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/sram_tap_chk.sv
module sram_tap_chk
    import sram_tap_pkg::*;
(
    input logic             tck,
    input logic             rst,
    input tap_state_e       st,
    input tap_state_e       nxt,
    input logic             tdo_en,
    input logic             hiz_req,
    input logic [BSR_W-1:0] bsr_update
);
    // R1: reset values visible on the first cycle after release
    a_r1_reset_values: assert property (@(posedge tck) disable iff (rst)
        $past(rst) |-> (!hiz_req && bsr_update == '0 && !tdo_en));

    // R2: entering Test-Logic-Reset drops the float request
    a_r2_tlr_clears_hiz: assert property (@(posedge tck) disable iff (rst)
        (nxt == S_TLR) |=> !hiz_req);

    // R8: update outputs move only when leaving Update-DR
    a_r8_update_only_in_upd_dr: assert property (@(posedge tck) disable iff (rst)
        (st != S_UPD_DR) |=> $stable(bsr_update));

    // R9: float request moves only at Update-IR or reset entry
    a_r9_hiz_only_update_ir: assert property (@(posedge tck) disable iff (rst)
        (st != S_UPD_IR && nxt != S_TLR) |=> $stable(hiz_req));

    // R10: output enable reflects the shift states across the falling edge
    a_r10_tdo_en_in_shift: assert property (@(posedge tck) disable iff (rst)
        tdo_en == (st == S_SHF_IR || st == S_SHF_DR));
endmodule

bind sram_tap sram_tap_chk u_chk (
    .tck        (tck),
    .rst        (tap_reset),
    .st         (st),
    .nxt        (nxt),
    .tdo_en     (tdo_en),
    .hiz_req    (hiz_req),
    .bsr_update (bsr_update)
);

// File: tb/sim_sram_tap.sv
module sim_sram_tap;
    localparam int BW = 71;

    logic          tck = 1'b0;
    logic          tap_reset = 1'b1;
    logic          tms = 1'b1;
    logic          tdi = 1'b0;
    logic          tdo;
    logic          tdo_en;
    logic          hiz_req;
    logic [BW-1:0] bsr_capture = '0;
    logic [BW-1:0] bsr_update;

    int total = 0;
    int bad   = 0;
    logic last_en;

    always #4 tck = ~tck;

    sram_tap u0 (
        .tck(tck), .tap_reset(tap_reset), .tms(tms), .tdi(tdi),
        .tdo(tdo), .tdo_en(tdo_en), .hiz_req(hiz_req),
        .bsr_capture(bsr_capture), .bsr_update(bsr_update)
    );

    function automatic logic [31:0] exp_id();
        return {3'b000, 5'b01011, 6'b000000, 6'b100110, 11'b00000110100, 1'b1};
    endfunction

    task automatic chk(input logic ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d, output logic so);
        @(negedge tck);
        #1 tms = m; tdi = d;
        #1 so = tdo; last_en = tdo_en;
        @(posedge tck);
        #1;
    endtask

    task automatic scan_ir(input logic [2:0] code, output logic [2:0] cap,
                           output logic pre_hiz);
        logic so;
        step(1, 0, so); step(1, 0, so); step(0, 0, so); step(0, 0, so);
        for (int i = 0; i < 3; i++) begin
            step(i == 2, code[i], so);
            cap[i] = so;
        end
        pre_hiz = hiz_req;
        step(1, 0, so); step(0, 0, so);
    endtask

    task automatic scan_dr(input int n, input logic [127:0] din,
                           output logic [127:0] dout, output logic [BW-1:0] pre_upd);
        logic so;
        dout = '0;
        step(1, 0, so); step(0, 0, so); step(0, 0, so);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i], so);
            dout[i] = so;
        end
        chk(last_en === 1'b1, "R10 tdo_en during shift", {127'd0, last_en}, 1);
        pre_upd = bsr_update;
        step(1, 0, so); step(0, 0, so);
        chk(tdo_en === 1'b0 && tdo === 1'b0, "R10 quiet outside shift",
            {126'd0, tdo_en, tdo}, 0);
    endtask

    task automatic t_reset();
        logic so;
        tap_reset = 1'b1;
        repeat (3) @(posedge tck);
        #1;
        chk(hiz_req === 1'b0, "R1 hiz after reset", {127'd0, hiz_req}, 0);
        chk(bsr_update === '0, "R1 update after reset", {57'd0, bsr_update}, 0);
        chk(tdo_en === 1'b0, "R1 tdo_en after reset", {127'd0, tdo_en}, 0);
        @(negedge tck);
        #1 tap_reset = 1'b0;
        step(0, 0, so);
    endtask

    task automatic t_idcode_default();
        logic [127:0] o; logic [BW-1:0] pu;
        scan_dr(32, 128'h0, o, pu);
        chk(o[31:0] === exp_id(), "R5 id word", o, {96'd0, exp_id()});
    endtask

    task automatic t_ir_capture();
        logic [2:0] cap; logic ph;
        scan_ir(3'b001, cap, ph);
        chk(cap === 3'b001, "R4 capture-ir pattern", {125'd0, cap}, 1);
    endtask

    task automatic t_bypass(input logic [2:0] code, input string tag);
        logic [2:0] cap; logic ph; logic [127:0] o; logic [127:0] din; logic [BW-1:0] pu;
        logic [127:0] e;
        scan_ir(code, cap, ph);
        chk(hiz_req === 1'b0, {tag, " no float"}, {127'd0, hiz_req}, 0);
        din = 128'h0000_0000_0000_0000_0000_0000_B5C3_9A6E;
        scan_dr(32, din, o, pu);
        e = {din[126:0], 1'b0};
        chk(o[31:0] === e[31:0], {tag, " one-cycle delay"}, o, {96'd0, e[31:0]});
    endtask

    task automatic t_sample_preload();
        logic [2:0] cap; logic ph; logic [127:0] o; logic [127:0] din; logic [BW-1:0] pu;
        bsr_capture = {7'h2A, 64'hF00D_1234_5678_9ABC};
        scan_ir(3'b100, cap, ph);
        chk(hiz_req === 1'b0, "R9 sample/preload no float", {127'd0, hiz_req}, 0);
        din = {57'd0, 7'h13, 64'h0F0F_A5A5_3C3C_1111};
        scan_dr(BW, din, o, pu);
        chk(o[BW-1:0] === bsr_capture, "R7 sample/preload capture",
            o, {57'd0, bsr_capture});
        chk(pu === '0, "R8 no update before Update-DR", {57'd0, pu}, 0);
        chk(bsr_update === din[BW-1:0], "R8 preload update",
            {57'd0, bsr_update}, din);
    endtask

    task automatic t_sample_z();
        logic [2:0] cap; logic ph; logic [127:0] o; logic [BW-1:0] pu;
        bsr_capture = {7'h55, 64'h0123_4567_89AB_CDEF};
        scan_ir(3'b010, cap, ph);
        chk(ph === 1'b0, "R9 float waits for Update-IR", {127'd0, ph}, 0);
        chk(hiz_req === 1'b1, "R9 sample-with-float raises float", {127'd0, hiz_req}, 1);
        scan_dr(BW, {57'd0, bsr_capture}, o, pu);
        chk(o[BW-1:0] === bsr_capture, "R7 sample-with-float capture",
            o, {57'd0, bsr_capture});
    endtask

    task automatic t_extest();
        logic [2:0] cap; logic ph; logic [127:0] o; logic [127:0] din; logic [BW-1:0] pu;
        bsr_capture = {7'h61, 64'hDEAD_BEEF_CAFE_0042};
        scan_ir(3'b000, cap, ph);
        chk(hiz_req === 1'b1, "R9 external test float", {127'd0, hiz_req}, 1);
        din = {56'd0, 8'hC7, 64'h8421_7E7E_1357_2468};
        scan_dr(BW + 1, din, o, pu);
        chk(o[BW-1:0] === bsr_capture, "R7 external test capture",
            o, {57'd0, bsr_capture});
        chk(o[BW] === din[0], "R7 chain length 71", {127'd0, o[BW]}, {127'd0, din[0]});
        chk(bsr_update === din[BW:1], "R8 external test update",
            {57'd0, bsr_update}, {57'd0, din[BW:1]});
    endtask

    task automatic t_idcode_keeps_update();
        logic [2:0] cap; logic ph; logic [127:0] o; logic [BW-1:0] pu; logic [BW-1:0] held;
        held = bsr_update;
        scan_ir(3'b001, cap, ph);
        chk(hiz_req === 1'b0, "R3 identification clears float", {127'd0, hiz_req}, 0);
        scan_dr(32, 128'hFFFF_FFFF, o, pu);
        chk(o[31:0] === exp_id(), "R5 id after reload", o, {96'd0, exp_id()});
        chk(bsr_update === held, "R8 id scan leaves update",
            {57'd0, bsr_update}, {57'd0, held});
    endtask

    task automatic t_tms_reset();
        logic [2:0] cap; logic ph; logic so; logic [127:0] o; logic [BW-1:0] pu;
        scan_ir(3'b000, cap, ph);
        step(1, 0, so); step(0, 0, so); step(0, 0, so);
        for (int i = 0; i < 4; i++) step(1, 0, so);
        chk(hiz_req === 1'b1, "R2 four TMS-high edges keep instruction",
            {127'd0, hiz_req}, 1);
        step(1, 0, so);
        chk(hiz_req === 1'b0, "R2 fifth TMS-high edge resets", {127'd0, hiz_req}, 0);
        step(0, 0, so);
        scan_dr(32, 128'h0, o, pu);
        chk(o[31:0] === exp_id(), "R2 identification after TMS reset",
            o, {96'd0, exp_id()});
    endtask

    initial begin
        #(8 * 150000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_idcode_default();
        t_ir_capture();
        t_bypass(3'b111, "R6 bypass");
        t_bypass(3'b011, "R3 reserved 011");
        t_bypass(3'b101, "R3 reserved 101");
        t_bypass(3'b110, "R3 reserved 110");
        t_sample_preload();
        t_sample_z();
        t_extest();
        t_idcode_keeps_update();
        t_tms_reset();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule